// File: doc/BRIEF.md
# Programmable Baud Enable Generator

This block divides the system clock into a stream of single-cycle enable pulses. The pulses are meant to run at sixteen times the serial bit rate, so that a transmitter and a receiver can oversample each bit. The spacing between pulses is a divisor that the processor loads at run time. Because the divisor is not fixed, one build keeps the same serial bit rate on different input clocks. For example, a 20 MHz clock at 9600 bit/s needs a divisor of 130, and a 5 MHz clock at 4800 bit/s needs 65. The divisor is the clock frequency divided by sixteen times the bit rate, rounded.

The divisor is written one byte lane per access. A write to the most significant lane commits the full value and restarts the count, so a new rate starts on a clean boundary. A write to a lower lane only changes the stored value. That value is used from the next reload onwards. By default the output is registered and the divisor is two 8-bit lanes.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the stored divisor is zero and `baud_en` stays low until a non-zero divisor is committed.
- R2: With `wr_en` high, lane index 0 writes divisor bits 7:0 and lane index 1 writes bits 15:8. The committed divisor is the concatenation of all lanes.
- R3: A write to the most significant lane restarts the count and forces `baud_en` low. For a committed divisor D, the first pulse appears in the cycle that follows the D-th rising edge after the committing edge.
- R4: With divisor D of 1 or more and no further writes, successive pulses are exactly D clock cycles apart.
- R5: For D of 2 or more each pulse is high for exactly one cycle. For D equal to 1, `baud_en` stays high every cycle.
- R6: A divisor of zero keeps `baud_en` low indefinitely.
- R7: A write to a lower lane does not restart the count. The current interval completes with its old length, and the following intervals use the new divisor.
- R8: The divisors 65 and 130 give pulse periods of 65 and 130 cycles, which are the 16x rates for 4800 bit/s at 5 MHz and 9600 bit/s at 20 MHz.
- R9: While `wr_en` is low, the values on `wr_lane` and `wr_data` have no effect on the pulse period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one divisor lane |
| wr_lane | input | 1 | Lane index (0 = low byte, 1 = high byte) |
| wr_data | input | 8 | Byte written into the selected lane |
| baud_en | output | 1 | Enable pulse at the programmed rate |

## Verification
The assertions check several properties on every cycle. The count always steps down by one while it is non-zero. A commit always clears the output. A zero divisor never yields a pulse. Every pulse follows a cycle in which the count was zero. For divisors of 2 or more, a pulse never lasts two cycles.

Some behaviours can only be shown by the bench's scenarios, because they span a whole interval:
- the exact spacing between pulses for each divisor;
- the delay from a commit to the first pulse;
- the deferred effect of a low-lane write;
- the fact that idle bus values are ignored.

For these the bench sweeps divisors 1 to 40 and a set of larger values, and compares each measured interval against the divisor itself.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

   typedef enum logic {
      OUT_REGISTERED = 1'b0,
      OUT_DIRECT     = 1'b1
   } out_mode_e;

   function automatic int lane_addr_bits(input int lanes);
      return (lanes <= 1) ? 1 : $clog2(lanes);
   endfunction

endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
   parameter int BYTE_W    = 8,
   parameter int NUM_LANES = 2,
   parameter int ADDR_W    = 1,
   localparam int DIV_W    = BYTE_W * NUM_LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_lane,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [DIV_W-1:0]  div_q,
   output logic [DIV_W-1:0]  div_next,
   output logic              top_wr
);

   localparam logic [ADDR_W-1:0] TOP_LANE = ADDR_W'(NUM_LANES - 1);

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      logic              hit;
      logic [BYTE_W-1:0] lane_q;

      assign hit = wr_en && (wr_lane == ADDR_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n)   lane_q <= '0;
         else if (hit) lane_q <= wr_data;
      end

      assign div_q[g*BYTE_W +: BYTE_W]    = lane_q;
      assign div_next[g*BYTE_W +: BYTE_W] = hit ? wr_data : lane_q;
   end

   assign top_wr = wr_en && (wr_lane == TOP_LANE);

endmodule

// File: rtl/baud_down_cnt.sv
module baud_down_cnt #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] load_div,
   input  logic [DIV_W-1:0] run_div,
   output logic [DIV_W-1:0] cnt_q,
   output logic             tick
);

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   assign tick = (cnt_q == '0) && (run_div != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= (load_div == '0) ? '0 : load_div - ONE;
      else if (tick)           cnt_q <= run_div - ONE;
      else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
   end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_tick_pkg::*;
#(
   parameter int        BYTE_W    = 8,
   parameter int        NUM_LANES = 2,
   parameter out_mode_e OUT_MODE  = OUT_REGISTERED,
   localparam int       ADDR_W    = lane_addr_bits(NUM_LANES),
   localparam int       DIV_W     = BYTE_W * NUM_LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_lane,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              baud_en
);

   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be at least 1");
   end
   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("NUM_LANES must be at least 1");
   end
   if (DIV_W > 64) begin : g_bad_width
      $error("divisor wider than 64 bits");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_next;
   logic [DIV_W-1:0] cnt_q;
   logic             hi_wr;
   logic             tick;

   baud_div_regs #(
      .BYTE_W    (BYTE_W),
      .NUM_LANES (NUM_LANES),
      .ADDR_W    (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_lane  (wr_lane),
      .wr_data  (wr_data),
      .div_q    (div_q),
      .div_next (div_next),
      .top_wr   (hi_wr)
   );

   baud_down_cnt #(
      .DIV_W (DIV_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (hi_wr),
      .load_div (div_next),
      .run_div  (div_q),
      .cnt_q    (cnt_q),
      .tick     (tick)
   );

   if (OUT_MODE == OUT_REGISTERED) begin : g_out_reg
      logic en_q;
      always_ff @(posedge clk) begin
         if (!rst_n)     en_q <= 1'b0;
         else if (hi_wr) en_q <= 1'b0;
         else            en_q <= tick;
      end
      assign baud_en = en_q;
   end else begin : g_out_dir
      assign baud_en = tick;
   end

endmodule

// File: rtl/baud_tick_chk.sv
module baud_tick_chk #(
   parameter int DIV_W      = 16,
   parameter bit REGISTERED = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load,
   input logic [DIV_W-1:0] div_q,
   input logic [DIV_W-1:0] cnt,
   input logic             baud_en
);

   // R4: the count walks down one step per cycle between reloads
   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !load) |=> (cnt == $past(cnt) - DIV_W'(1)));

   if (REGISTERED) begin : g_reg_checks
      assert_reload_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
         load |=> !baud_en);

      assert_zero_div_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (div_q == '0 && !load) |=> !baud_en);

      assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (baud_en && $past(div_q) >= DIV_W'(2)) |=> !baud_en);

      assert_pulse_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         baud_en |-> ($past(cnt) == '0 && $past(div_q) != '0));
   end

endmodule

bind baud_tick_gen baud_tick_chk #(
   .DIV_W      (DIV_W),
   .REGISTERED (OUT_MODE == baud_tick_pkg::OUT_REGISTERED)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .load    (hi_wr),
   .div_q   (div_q),
   .cnt     (cnt_q),
   .baud_en (baud_en)
);

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [0:0] wr_lane = '0;
   logic [7:0] wr_data = '0;
   logic       baud_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   baud_tick_gen dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_lane (wr_lane),
      .wr_data (wr_data),
      .baud_en (baud_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_lane(input int lane, input int val);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_lane = lane[0:0];
      wr_data = val[7:0];
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic set_div(input int d);
      write_lane(0, d & 255);
      write_lane(1, (d >> 8) & 255);
   endtask

   // count falling edges until baud_en is seen high
   task automatic wait_pulse(output int n, input int limit);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!baud_en && n < limit);
   endtask

   task automatic run_div(input int d, input string req);
      int n;
      set_div(d);
      wait_pulse(n, d + 4);
      check(n == d, {req, " first pulse R3"}, n, d);
      if (d == 1) begin
         int hi = 0;
         for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (baud_en) hi++;
         end
         check(hi == 5, "R5 divisor 1 held high", hi, 5);
      end else begin
         for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check(!baud_en, "R5 pulse width", int'(baud_en), 0);
            wait_pulse(n, d + 4);
            n++;
            check(n == d, {req, " period R4"}, n, d);
         end
      end
   endtask

   initial begin
      int n;
      int hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: quiet after reset
      hi = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (baud_en) hi++;
      end
      check(hi == 0, "R1 no pulse after reset", hi, 0);

      // R3 R4 R5: sweep of small divisors
      for (int d = 1; d <= 40; d++) run_div(d, "R4 sweep");

      // R8: 16x rates for the two clock/rate pairs
      run_div(65, "R8 5MHz 4800");
      run_div(130, "R8 20MHz 9600");

      // R2: lane placement, values spanning both bytes
      run_div(255, "R2 low lane full");
      run_div(256, "R2 high lane bit");
      run_div(300, "R2 mixed lanes");
      run_div(1000, "R2 large");

      // R7: low-lane write mid-interval
      set_div(10);
      wait_pulse(n, 14);
      check(n == 10, "R7 setup", n, 10);
      repeat (2) @(negedge clk);
      write_lane(0, 25);
      wait_pulse(n, 14);
      check(n == 6, "R7 old interval completes", n, 6);
      wait_pulse(n, 30);
      check(n == 25, "R7 new divisor applied", n, 25);

      // R9: bus activity without wr_en
      set_div(10);
      wait_pulse(n, 14);
      @(negedge clk);
      wr_lane = 1'b1;
      wr_data = 8'hFF;
      for (int k = 0; k < 3; k++) begin
         wait_pulse(n, 14);
         if (k == 0) n++;
         check(n == 10, "R9 idle bus ignored", n, 10);
      end
      wr_lane = 1'b0;
      wr_data = '0;

      // R6: zero divisor
      set_div(0);
      hi = 0;
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         if (baud_en) hi++;
      end
      check(hi == 0, "R6 zero divisor quiet", hi, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule